// File: doc/BRIEF.md
# Quadrature Clock Phase Generator

This block divides a parent clock by two and places the edges of the resulting clock at one of four quarter-period offsets. An optional fine delay then shifts the chosen clock later by a whole number of delay taps. A storage-card host can use the block to set up a drive clock or a sample clock whose phase software can adjust to meet the card's timing window.

All settings sit in one control word. The upper half of every write is a per-bit enable for the lower half, so software can change one field without a read-modify-write. Phase offsets that are odd multiples of a quarter period are made by capturing the divider on the falling edge of the parent clock. A new quadrant is adopted only at the parent rising edge where the 0-degree divider goes high. The fine delay is modelled as a chain of flops clocked by an oversampling clock, with one tap per chain stage.

Top module: `qphase_clkgen`

## Requirements
- R1: `clk_out` toggles with a period of exactly two parent clock periods, with its rising edges one output period apart.
- R2: While `rst_n` is low, `rd_data` reads 0 and `clk_out` is low. With the reset setting (0 degrees, fine delay off), the first rising edge of `clk_out` falls on the first rising edge of `clk_par` after reset is released.
- R3: Control bits [1:0] select the quadrant. Values 0, 1, 2 and 3 place the rising edge of `clk_out` 0, 1/2, 1 and 3/2 parent periods later than it sits at setting 0.
- R4: Control bit 10 turns the fine delay on. While bit 10 is 0, the count in bits [9:2] has no effect on `clk_out`.
- R5: With bit 10 set and count N in bits [9:2] (0 to 255), `clk_out` is the coarse clock taken after N stages of a flop chain clocked by `clk_os`. N = 0 adds no delay.
- R6: When `wr_en` is high on a rising edge of `clk_par`, each lower bit i (0 to 15) of the register takes `wr_data[i]` only if `wr_data[16+i]` is 1. Every other bit keeps its value, and nothing changes while `wr_en` is low.
- R7: `rd_data[15:0]` returns all 16 stored bits, including bits 11 to 15, which have no function. `rd_data[31:16]` reads 0.
- R8: The quadrant in use is reloaded only at the `clk_par` rising edge where the 0-degree divider rises, and it takes the register value from before that edge. A write that lands on that same edge therefore takes effect one output period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_par | input | 1 | Parent clock, also the register clock |
| clk_os | input | 1 | Oversampling clock that stands in for the fine delay taps |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge of `clk_par` |
| wr_data | input | 32 | Upper half is the write-enable mask, lower half is the new value |
| rd_data | output | 32 | Stored control word in the lower half, zeros in the upper half |
| clk_out | output | 1 | Half-rate clock with the selected phase |

## Verification
A register write and a quadrant reload can fall on the same `clk_par` edge, at the moment the 0-degree divider rises. The bench first learns where that edge sits from the first output edge after reset. It then times a write so that the edge samples it, and changes the quadrant from 0 to 2. The check passes only if the next output rise still has the old phase (80 ns after the previous one) and the rise after that comes 120 ns later, with no rise in between.

// File: rtl/qpg_pkg.sv
`timescale 1ns/1ps
package qpg_pkg;
   localparam int DEF_HALF_W = 16;
   localparam int DEF_CNT_W  = 8;

   typedef enum logic [1:0] {
      QD_0   = 2'd0,
      QD_90  = 2'd1,
      QD_180 = 2'd2,
      QD_270 = 2'd3
   } quad_e;
endpackage

// File: rtl/qpg_ctrl_reg.sv
`timescale 1ns/1ps
module qpg_ctrl_reg #(
   parameter int HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [2*HALF_W-1:0]   wr_data,
   output logic [HALF_W-1:0]     cfg_q
);
   localparam int WORD_W = 2 * HALF_W;

   logic [HALF_W-1:0] bit_en;
   logic [HALF_W-1:0] bit_val;

   assign bit_en  = wr_data[WORD_W-1:HALF_W];
   assign bit_val = wr_data[HALF_W-1:0];

   for (genvar i = 0; i < HALF_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[i] <= 1'b0;
         else if (wr_en && bit_en[i])
            cfg_q[i] <= bit_val[i];
      end
   end

   // R6
   masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((cfg_q ^ $past(cfg_q)) & ~$past(wr_data[WORD_W-1:HALF_W])) == '0);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/qpg_quad_div.sv
`timescale 1ns/1ps
module qpg_quad_div
   import qpg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] quad_req,
   output logic       phase_out
);
   logic  div_p;
   logic  div_n;
   quad_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_p <= 1'b0;
      else
         div_p <= ~div_p;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)
         div_n <= 1'b0;
      else
         div_n <= div_p;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= QD_0;
      else if (!div_p)
         sel_q <= quad_e'(quad_req);
   end

   always_comb begin
      unique case (sel_q)
         QD_0:    phase_out = div_p;
         QD_90:   phase_out = div_n;
         QD_180:  phase_out = ~div_p;
         default: phase_out = ~div_n;
      endcase
   end

   // R1
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (div_p != $past(div_p)));

   // R3
   half_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_n == div_p);

   // R8
   sel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_q) |-> $rose(div_p));
endmodule

// File: rtl/qpg_fine_dly.sv
`timescale 1ns/1ps
module qpg_fine_dly #(
   parameter int CNT_W   = 8,
   parameter bit FINE_EN = 1'b1
) (
   input  logic             clk_os,
   input  logic             rst_n,
   input  logic             din,
   input  logic             dly_en,
   input  logic [CNT_W-1:0] dly_cnt,
   output logic             dout
);
   localparam int TAPS = 1 << CNT_W;

   if (CNT_W < 2) begin : g_bad_width
      $error("qpg_fine_dly: CNT_W must be at least 2");
   end

   if (FINE_EN) begin : g_chain
      logic [TAPS-2:0] stage_q;
      logic [TAPS-1:0] tap;

      always_ff @(posedge clk_os or negedge rst_n) begin
         if (!rst_n)
            stage_q <= '0;
         else
            stage_q <= {stage_q[TAPS-3:0], din};
      end

      assign tap  = {stage_q, din};
      assign dout = dly_en ? tap[dly_cnt] : din;
   end else begin : g_bypass
      logic unused_fine;
      assign unused_fine = ^{clk_os, rst_n, dly_en, dly_cnt};
      assign dout = din;
   end
endmodule

// File: rtl/qphase_clkgen.sv
`timescale 1ns/1ps
module qphase_clkgen
   import qpg_pkg::*;
#(
   parameter int HALF_W   = DEF_HALF_W,
   parameter int CNT_W    = DEF_CNT_W,
   parameter int QUAD_LSB = 0,
   parameter int CNT_LSB  = 2,
   parameter int SEL_BIT  = 10,
   parameter bit FINE_EN  = 1'b1
) (
   input  logic                 clk_par,
   input  logic                 clk_os,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2*HALF_W-1:0]  wr_data,
   output logic [2*HALF_W-1:0]  rd_data,
   output logic                 clk_out
);
   localparam int QUAD_W = 2;
   localparam logic [HALF_W-1:0] USED_MASK = HALF_W'(
      (((1 << QUAD_W) - 1) << QUAD_LSB) |
      (((1 << CNT_W) - 1) << CNT_LSB) |
      (1 << SEL_BIT));

   if (SEL_BIT >= HALF_W) begin : g_bad_sel
      $error("qphase_clkgen: select bit lies outside the control half");
   end
   if (CNT_LSB + CNT_W > SEL_BIT || QUAD_LSB + QUAD_W > CNT_LSB) begin : g_bad_fields
      $error("qphase_clkgen: control fields overlap");
   end

   logic [HALF_W-1:0] cfg;
   logic [QUAD_W-1:0] quad;
   logic [CNT_W-1:0]  cnt;
   logic              dly_en;
   logic              coarse;
   logic              unused_cfg;

   qpg_ctrl_reg #(.HALF_W(HALF_W)) u_reg (
      .clk     (clk_par),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cfg_q   (cfg)
   );

   assign rd_data    = {{HALF_W{1'b0}}, cfg};
   assign quad       = cfg[QUAD_LSB +: QUAD_W];
   assign cnt        = cfg[CNT_LSB +: CNT_W];
   assign dly_en     = cfg[SEL_BIT];
   assign unused_cfg = ^(cfg & ~USED_MASK);

   qpg_quad_div u_div (
      .clk       (clk_par),
      .rst_n     (rst_n),
      .quad_req  (quad),
      .phase_out (coarse)
   );

   qpg_fine_dly #(.CNT_W(CNT_W), .FINE_EN(FINE_EN)) u_fine (
      .clk_os  (clk_os),
      .rst_n   (rst_n),
      .din     (coarse),
      .dly_en  (dly_en),
      .dly_cnt (cnt),
      .dout    (clk_out)
   );

   if (FINE_EN) begin : g_fine_chk
      // R4
      bypass_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
         !dly_en |-> (clk_out == coarse));

      // R5
      tap_one_chk: assert property (@(posedge clk_os) disable iff (!rst_n)
         (dly_en && cnt == CNT_W'(1)) |-> (clk_out == $past(coarse)));
   end
endmodule

// File: tb/qphase_clkgen_bench.sv
`timescale 1ns/1ps
module qphase_clkgen_bench;
   localparam int CLK_PERIOD = 40;
   localparam int OUT_PERIOD = 2 * CLK_PERIOD;
   localparam int OS_PERIOD  = 5;
   localparam int OS_OFS     = 1;
   localparam int SETTLE     = 40 * CLK_PERIOD;
   localparam int NVEC       = 10;

   localparam logic [31:0] VW [NVEC] = '{
      32'hFFFF_0001, 32'hFFFF_0003, 32'h0003_0002, 32'h07FC_0414, 32'h0400_0000,
      32'h0000_FFFF, 32'hFFFF_07FD, 32'hFFFF_0400, 32'hF800_A800, 32'hFFFF_0408};
   localparam logic [15:0] VR [NVEC] = '{
      16'h0001, 16'h0003, 16'h0002, 16'h0416, 16'h0016,
      16'h0016, 16'h07FD, 16'h0400, 16'hAC00, 16'h0408};
   localparam int VQ [NVEC] = '{1, 3, 2, 2, 2, 2, 1, 0, 0, 0};
   localparam int VK [NVEC] = '{0, 0, 0, 5, 0, 0, 255, 0, 0, 2};

   logic        clk_par = 1'b0;
   logic        clk_os  = 1'b0;
   logic        rst_n   = 1'b0;
   logic        wr_en   = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        clk_out;

   int checks = 0;
   int errors = 0;
   int last_rise = -1;
   int ref_ofs = 0;
   event rise_ev;

   qphase_clkgen u_qphase_clkgen (
      .clk_par (clk_par),
      .clk_os  (clk_os),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .clk_out (clk_out)
   );

   initial forever #(CLK_PERIOD / 2) clk_par = ~clk_par;

   initial begin
      #(OS_OFS);
      clk_os = 1'b1;
      forever #(OS_PERIOD / 2.0) clk_os = ~clk_os;
   end

   // edge recorder: samples halfway between integer nanoseconds
   initial begin
      logic prev_v;
      int   tick;
      prev_v = 1'b0;
      tick   = 0;
      #0.5;
      forever begin
         if (clk_out === 1'b1 && prev_v === 1'b0) begin
            last_rise = tick;
            -> rise_ev;
         end
         prev_v = clk_out;
         tick++;
         #1;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic do_write(input logic [31:0] d);
      @(posedge clk_par);
      #10;
      wr_en   = 1'b1;
      wr_data = d;
      @(posedge clk_par);
      #10;
      wr_en = 1'b0;
   endtask

   function automatic int fine_ns(input int k);
      return (k == 0) ? 0 : OS_OFS + OS_PERIOD * (k - 1);
   endfunction

   function automatic int wrap(input int v);
      return ((v % OUT_PERIOD) + OUT_PERIOD) % OUT_PERIOD;
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int r1;
      int r2;
      int t_a;
      logic [31:0] held;

      // R2: reset state
      #45;
      chk("R2 rd_data in reset", rd_data, 0);
      chk("R2 clk_out in reset", clk_out, 0);
      #5;
      rst_n = 1'b1;
      @(rise_ev);
      chk("R2 first rise time", last_rise, 60);
      ref_ofs = wrap(last_rise);
      @(rise_ev);
      chk("R1 period after reset", last_rise - 60, OUT_PERIOD);

      // vector table: R3 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         do_write(VW[i]);
         chk($sformatf("R6 R7 readback vec %0d", i), rd_data, {16'h0000, VR[i]});
         #(SETTLE);
         @(rise_ev);
         r1 = last_rise;
         @(rise_ev);
         r2 = last_rise;
         chk($sformatf("R1 period vec %0d", i), r2 - r1, OUT_PERIOD);
         chk($sformatf("R3 R4 R5 phase vec %0d", i), wrap(r2 - ref_ofs),
             wrap(VQ[i] * (CLK_PERIOD / 2) + fine_ns(VK[i])));
      end

      // R6: bus activity without wr_en leaves the register alone
      held = rd_data;
      @(posedge clk_par);
      #10;
      wr_data = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk_par);
      #10;
      chk("R6 write ignored while wr_en low", rd_data, held);
      chk("R7 upper half reads zero", rd_data[31:16], 0);

      // R8: write lands on the edge where the divider rises
      do_write(32'hFFFF_0000);
      #(SETTLE);
      @(rise_ev);
      t_a = last_rise;
      #49.5;
      wr_en   = 1'b1;
      wr_data = 32'h0003_0002;
      @(rise_ev);
      r1 = last_rise;
      #9.5;
      wr_en = 1'b0;
      @(rise_ev);
      r2 = last_rise;
      chk("R8 old quadrant kept on write edge", r1 - t_a, OUT_PERIOD);
      chk("R8 new quadrant one period later", r2 - t_a, OUT_PERIOD + OUT_PERIOD + CLK_PERIOD);
      chk("R8 readback after coincident write", rd_data, 32'h0000_0002);

      finish_run();
   end
endmodule